// File: doc/BRIEF.md
# Host-side parallel ADC bus master

This block sits on the host side of a 12-bit successive-approximation converter with a multiplexed parallel bus. It runs the converter's chip select, write and read strobes and its clock, and drives or releases the shared data lines. Each request names an input address, single-ended or pseudo-differential input, unipolar or bipolar range and a power field. The master writes the matching control byte and waits for the converter's active-low completion flag. It then reads the 12-bit code and emits it on a one-cycle result strobe, tagged with the address of the request that produced it.

In normal ordering every sample is a write, a wait and a read. In pipelined ordering, when a result is already waiting in the converter and a new request arrives, the master first writes the new control byte. That starts the next acquisition, and only then does it read the waiting result. This removes the read from the critical loop. Results in this mode carry the tag of the earlier request. A waiting result is read out on its own when no request is pending. All bus timing is set in system clock cycles by parameters. A timeout reports a conversion whose completion flag never arrives.

Top module: `adc_host_master`

## Requirements
- R1: For PWRUP_CYC system clocks after reset is released, req_ready stays low and adc_cs_n, adc_wr_n and adc_rd_n stay high. No write happens in that window.
- R2: The written byte is bus_out[7:0]. Bits 7:6 carry req_pwr, bit 5 is 0 (internally timed acquisition), bit 4 is req_single (1 single-ended, 0 pseudo-differential), bit 3 is req_unipolar (1 unipolar, 0 bipolar) and bits 2:0 carry req_chan. bus_out[11:8] is 0.
- R3: Chip select is low for at least CS_SETUP cycles before adc_wr_n falls. adc_wr_n stays low for exactly WR_LEN cycles. bus_oe is high and bus_out is stable throughout that time.
- R4: bus_oe is low whenever adc_rd_n is low, and it is already low in the cycle before adc_rd_n falls.
- R5: adc_rd_n stays low for exactly RD_LEN cycles. res_data is bus_in as sampled in the last of those cycles. res_valid is high for exactly the one cycle after adc_rd_n returns high.
- R6: With pipe_mode low, each request is written, the master waits for adc_int_n low, and then it reads. The result carries the data of that same conversion, with res_chan equal to that request's req_chan.
- R7: With pipe_mode high and a result waiting, a newly accepted request is written before the waiting result is read. That result carries res_chan of the previous request.
- R8: With pipe_mode high, a waiting result is read out when the master is idle and req_valid is low. It is tagged with the last request's channel.
- R9: If adc_int_n is not seen low within TMO_CLKS falling edges of adc_clk after the write ends, tmo_err pulses for one cycle. No result is emitted, and req_ready is high in that same cycle.
- R10: adc_clk runs continuously after reset, with high and low phases of exactly CLK_HALF system clocks each.
- R11: adc_wr_n and adc_rd_n are never low together, and neither is low while adc_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 selects pipelined ordering, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and able to accept |
| req_chan | input | 3 | Input address |
| req_single | input | 1 | 1 single-ended, 0 pseudo-differential |
| req_unipolar | input | 1 | 1 unipolar, 0 bipolar |
| req_pwr | input | 2 | Power field of the control byte |
| adc_clk | output | 1 | Converter clock |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| bus_oe | output | 1 | Drive enable for the shared data lines |
| bus_out | output | DW | Data driven onto the bus |
| bus_in | input | DW | Data seen on the bus |
| adc_int_n | input | 1 | Converter completion flag, active low |
| res_valid | output | 1 | Result strobe |
| res_data | output | DW | Conversion code |
| res_chan | output | 3 | Address tag of the result |
| tmo_err | output | 1 | One-cycle timeout pulse |

## Verification
A corrupted sequencer state would show up at the pins within one strobe. Examples are a strobe without chip select, a drive enable overlapping a read, or a write or read of the wrong length. These are caught in the cycle they happen. A wrong tag or a wrong ordering register shows up only at the next result. In pipelined mode it can show as a result whose code or tag belongs to the neighbouring request, or as a read that comes before the next write. It is visible on the result strobe one sample later. A lost completion flag shows as a timeout pulse after TMO_CLKS converter clocks, never as a hang.

// File: rtl/adc_host_master.sv
module adc_host_master #(
  parameter int DW        = 12,
  parameter int CLK_HALF  = 7,
  parameter int PWRUP_CYC = 1000,
  parameter int CS_SETUP  = 4,
  parameter int WR_LEN    = 6,
  parameter int WR_HOLD   = 2,
  parameter int RD_LEN    = 6,
  parameter int TMO_CLKS  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_chan,
  input  logic          req_single,
  input  logic          req_unipolar,
  input  logic [1:0]    req_pwr,
  output logic          adc_clk,
  output logic          adc_cs_n,
  output logic          adc_wr_n,
  output logic          adc_rd_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  input  logic [DW-1:0] bus_in,
  input  logic          adc_int_n,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic [2:0]    res_chan,
  output logic          tmo_err
);
  localparam int CNT_W = $clog2(PWRUP_CYC + CS_SETUP + WR_LEN + WR_HOLD + RD_LEN + 1);
  localparam int TMO_W = $clog2(TMO_CLKS + 1);
  localparam int DIV_W = $clog2(CLK_HALF + 1);

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_CSW, ST_WR, ST_WH, ST_WAIT, ST_CSR, ST_RD
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt, limit;
  logic [TMO_W-1:0] tmo_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       ctrl;
  logic [2:0]       cur_tag, prev_tag, rd_tag;
  logic             pending, pipe_q, wr_then_rd, rd_then_wait;
  logic [1:0]       int_sync;
  logic             clk_q, div_wrap, adc_fall, phase_done, int_low;

  assign div_wrap = div_cnt == DIV_W'(CLK_HALF - 1);
  assign adc_fall = div_wrap && clk_q;
  assign adc_clk  = clk_q;
  assign int_low  = !int_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt  <= '0;
      clk_q    <= 1'b0;
      int_sync <= 2'b11;
    end else begin
      div_cnt  <= div_wrap ? '0 : div_cnt + 1'b1;
      if (div_wrap) clk_q <= ~clk_q;
      int_sync <= {int_sync[0], adc_int_n};
    end

  always_comb
    case (state)
      ST_BOOT:         limit = CNT_W'(PWRUP_CYC);
      ST_CSW, ST_CSR:  limit = CNT_W'(CS_SETUP);
      ST_WR:           limit = CNT_W'(WR_LEN);
      ST_WH:           limit = CNT_W'(WR_HOLD);
      ST_RD:           limit = CNT_W'(RD_LEN);
      default:         limit = CNT_W'(1);
    endcase

  assign phase_done = cnt == limit - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state        <= ST_BOOT;
      cnt          <= '0;
      tmo_cnt      <= '0;
      ctrl         <= '0;
      cur_tag      <= '0;
      prev_tag     <= '0;
      rd_tag       <= '0;
      pending      <= 1'b0;
      pipe_q       <= 1'b0;
      wr_then_rd   <= 1'b0;
      rd_then_wait <= 1'b0;
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_chan     <= '0;
      tmo_err      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      tmo_err   <= 1'b0;
      case (state)
        ST_BOOT:
          if (phase_done) begin state <= ST_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_IDLE:
          if (req_valid) begin
            ctrl       <= {req_pwr, 1'b0, req_single, req_unipolar, req_chan};
            prev_tag   <= cur_tag;
            cur_tag    <= req_chan;
            pipe_q     <= pipe_mode;
            wr_then_rd <= pending;
            pending    <= 1'b0;
            state      <= ST_CSW;
            cnt        <= '0;
          end else if (pending) begin
            pending      <= 1'b0;
            rd_tag       <= cur_tag;
            rd_then_wait <= 1'b0;
            state        <= ST_CSR;
            cnt          <= '0;
          end
        ST_CSW:
          if (phase_done) begin state <= ST_WR; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_WR:
          if (phase_done) begin state <= ST_WH; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_WH:
          if (phase_done) begin
            cnt     <= '0;
            tmo_cnt <= '0;
            if (wr_then_rd) begin
              rd_tag       <= prev_tag;
              rd_then_wait <= 1'b1;
              state        <= ST_CSR;
            end else state <= ST_WAIT;
          end else cnt <= cnt + 1'b1;
        ST_WAIT:
          if (int_low) begin
            if (pipe_q) begin
              pending <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              rd_tag       <= cur_tag;
              rd_then_wait <= 1'b0;
              state        <= ST_CSR;
              cnt          <= '0;
            end
          end else if (adc_fall) begin
            if (tmo_cnt == TMO_W'(TMO_CLKS - 1)) begin
              tmo_err <= 1'b1;
              state   <= ST_IDLE;
            end else tmo_cnt <= tmo_cnt + 1'b1;
          end
        ST_CSR:
          if (phase_done) begin state <= ST_RD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_RD:
          if (phase_done) begin
            res_valid <= 1'b1;
            res_data  <= bus_in;
            res_chan  <= rd_tag;
            cnt       <= '0;
            tmo_cnt   <= '0;
            state     <= rd_then_wait ? ST_WAIT : ST_IDLE;
          end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end

  assign req_ready = state == ST_IDLE;
  assign adc_cs_n  = !(state inside {ST_CSW, ST_WR, ST_WH, ST_CSR, ST_RD});
  assign adc_wr_n  = state != ST_WR;
  assign adc_rd_n  = state != ST_RD;
  assign bus_oe    = state inside {ST_CSW, ST_WR, ST_WH};
  assign bus_out   = {{(DW-8){1'b0}}, ctrl};
endmodule

// File: rtl/adc_host_master_chk.sv
module adc_host_master_chk #(
  parameter int DW        = 12,
  parameter int PWRUP_CYC = 1000,
  parameter int CS_SETUP  = 4,
  parameter int WR_LEN    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          adc_cs_n,
  input logic          adc_wr_n,
  input logic          adc_rd_n,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic          res_valid,
  input logic          tmo_err
);
  int unsigned boot_cnt, wr_lo, cs_lo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      boot_cnt <= 0;
      wr_lo    <= 0;
      cs_lo    <= 0;
    end else begin
      if (boot_cnt < PWRUP_CYC) boot_cnt <= boot_cnt + 1;
      wr_lo <= adc_wr_n ? 0 : wr_lo + 1;
      cs_lo <= adc_cs_n ? 0 : ((cs_lo < 255) ? cs_lo + 1 : cs_lo);
    end

  a_r1_quiet_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_cnt < PWRUP_CYC) |-> (!req_ready && adc_cs_n));
  a_r11_strobe_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_wr_n || !adc_rd_n) |-> !adc_cs_n);
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_wr_n |-> adc_rd_n);
  a_r3_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n) |-> (wr_lo == WR_LEN));
  a_r3_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_wr_n) |-> (cs_lo >= CS_SETUP));
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_wr_n |-> (bus_oe && $stable(bus_out)));
  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !bus_oe);
  a_r4_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> $past(!bus_oe));
  a_r5_valid_slot: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (adc_rd_n && $past(!adc_rd_n)));
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n) |-> res_valid);
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> !tmo_err);
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (req_ready && !res_valid));
endmodule

bind adc_host_master adc_host_master_chk #(
  .DW(DW), .PWRUP_CYC(PWRUP_CYC), .CS_SETUP(CS_SETUP), .WR_LEN(WR_LEN)
) u_chk (.*);

// File: tb/adc_host_master_test.sv
`timescale 1ns/1ps
module adc_host_master_test;
  localparam int DW = 12, CLK_HALF = 7, PWRUP_CYC = 1000, CS_SETUP = 4;
  localparam int WR_LEN = 6, WR_HOLD = 2, RD_LEN = 6, TMO_CLKS = 32;

  logic clk = 0, rst_n = 0;
  logic pipe_mode = 0, req_valid = 0, req_single = 0, req_unipolar = 0;
  logic [2:0] req_chan = 0;
  logic [1:0] req_pwr = 0;
  logic req_ready, adc_clk, adc_cs_n, adc_wr_n, adc_rd_n, bus_oe, res_valid, tmo_err;
  logic [DW-1:0] bus_out, bus_in, res_data;
  logic [2:0] res_chan;
  logic adc_int_n = 1;

  always #5 clk = ~clk;

  adc_host_master #(.DW(DW), .CLK_HALF(CLK_HALF), .PWRUP_CYC(PWRUP_CYC),
    .CS_SETUP(CS_SETUP), .WR_LEN(WR_LEN), .WR_HOLD(WR_HOLD), .RD_LEN(RD_LEN),
    .TMO_CLKS(TMO_CLKS)) uut (.*);

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter responder
  logic [7:0] lat = 0;
  logic [DW-1:0] result = 0;
  logic conv_on = 0, mute = 0;
  int fc = 0, nwr = 0, fall_cnt = 0, fall_at_wr = 0;
  logic [DW-1:0] wr_log [16];

  assign bus_in = (!adc_cs_n && !adc_rd_n) ? result : '1;

  always @(posedge adc_wr_n)
    if (adc_cs_n === 1'b0) begin
      lat = bus_out[7:0];
      if (nwr < 16) wr_log[nwr] = bus_out;
      nwr++;
      adc_int_n = 1;
      conv_on = 1;
      fc = 0;
      fall_at_wr = fall_cnt;
    end

  always @(negedge adc_clk) begin
    fall_cnt++;
    if (conv_on) begin
      fc++;
      if (fc == 16) begin
        conv_on = 0;
        if (!mute) begin
          result = {~lat[3:0], lat};
          adc_int_n = 0;
        end
      end
    end
  end

  always @(negedge adc_rd_n)
    if (adc_cs_n === 1'b0) adc_int_n = 1;

  // output collector and pin monitor
  logic [DW-1:0] res_log [16];
  int chan_log [16], nwr_at [16];
  int nres = 0, nerr = 0, err_falls = 0;
  int v_cs = 0, v_oe = 0, v_turn = 0, v_wroe = 0, v_wrlen = 0, v_setup = 0;
  int v_rdlen = 0, v_valid = 0, v_clk = 0, clk_edges = 0;
  int wr_run = 0, rd_run = 0, cs_run = 0, clk_run = 0;
  logic p_rd = 1, p_wr = 1, p_oe = 0, p_clk = 0;

  always @(negedge clk) if (rst_n) begin
    if (res_valid) begin
      if (nres < 16) begin
        res_log[nres] = res_data; chan_log[nres] = res_chan; nwr_at[nres] = nwr;
      end
      nres++;
    end
    if (tmo_err) begin nerr++; err_falls = fall_cnt - fall_at_wr; end
    if (((!adc_wr_n || !adc_rd_n) && adc_cs_n) || (!adc_wr_n && !adc_rd_n)) v_cs++;
    if (bus_oe && !adc_rd_n) v_oe++;
    if (p_rd && !adc_rd_n && p_oe) v_turn++;
    if (!adc_wr_n && !bus_oe) v_wroe++;
    cs_run = adc_cs_n ? 0 : cs_run + 1;
    if (p_wr && !adc_wr_n && (cs_run - 1 < CS_SETUP)) v_setup++;
    if (!adc_wr_n) wr_run++; else begin if (wr_run != 0 && wr_run != WR_LEN) v_wrlen++; wr_run = 0; end
    if (!adc_rd_n) rd_run++; else begin if (rd_run != 0 && rd_run != RD_LEN) v_rdlen++; rd_run = 0; end
    if (res_valid && !(adc_rd_n && !p_rd)) v_valid++;
    if (adc_clk == p_clk) clk_run++;
    else begin
      if (clk_edges > 0 && clk_run != CLK_HALF) v_clk++;
      clk_edges++; clk_run = 1;
    end
    p_rd = adc_rd_n; p_wr = adc_wr_n; p_oe = bus_oe; p_clk = adc_clk;
  end

  function automatic logic [7:0] ctl(input logic [2:0] ch, input logic s, input logic u,
                                    input logic [1:0] p);
    return {p, 1'b0, s, u, ch};
  endfunction
  function automatic logic [DW-1:0] code(input logic [7:0] c);
    return {~c[3:0], c};
  endfunction

  task automatic send(input logic [2:0] ch, input logic s, input logic u,
                      input logic [1:0] p, input bit drop);
    int n = 0;
    req_chan = ch; req_single = s; req_unipolar = u; req_pwr = p; req_valid = 1;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    if (drop) req_valid = 0;
  endtask

  task automatic wait_res(input int n);
    int k = 0;
    while (nres < n && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset;
    int k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(adc_cs_n && adc_wr_n && adc_rd_n && !bus_oe && !res_valid && !tmo_err,
          "R1", "idle pins after reset", {adc_cs_n, adc_wr_n, adc_rd_n, bus_oe}, 4'b1110);
    check(!req_ready, "R1", "ready at reset", req_ready, 0);
    repeat (500) @(negedge clk);
    k = 501;
    check(!req_ready && nwr == 0, "R1", "ready mid boot", req_ready, 0);
    while (!req_ready && k < 3000) begin @(negedge clk); k++; end
    check(k >= PWRUP_CYC && k <= PWRUP_CYC + 2, "R1", "boot length", k, PWRUP_CYC);
  endtask

  task automatic t_normal;
    logic [7:0] c;
    pipe_mode = 0;
    c = ctl(3'd5, 1, 1, 2'b11);
    send(3'd5, 1, 1, 2'b11, 1);
    wait_res(1);
    check(wr_log[0] == {4'h0, c}, "R2", "control byte single/unipolar", wr_log[0], c);
    check(res_log[0] == code(c), "R6", "normal result data", res_log[0], code(c));
    check(chan_log[0] == 5, "R6", "normal result tag", chan_log[0], 5);
    check(nwr_at[0] == 1, "R6", "read before next write", nwr_at[0], 1);
    c = ctl(3'd2, 0, 0, 2'b10);
    send(3'd2, 0, 0, 2'b10, 1);
    wait_res(2);
    check(wr_log[1] == {4'h0, c}, "R2", "control byte diff/bipolar", wr_log[1], c);
    check(res_log[1] == code(c) && chan_log[1] == 2, "R6", "second result",
          res_log[1], code(c));
    check(res_log[1] == bus_in_expected(c), "R5", "result equals bus code", res_log[1], code(c));
  endtask

  function automatic logic [DW-1:0] bus_in_expected(input logic [7:0] c);
    return code(c);
  endfunction

  task automatic t_pipe;
    logic [7:0] ca, cb, cc;
    int base;
    base = nres;
    pipe_mode = 1;
    ca = ctl(3'd1, 1, 0, 2'b11); cb = ctl(3'd3, 0, 1, 2'b11); cc = ctl(3'd4, 1, 1, 2'b11);
    send(3'd1, 1, 0, 2'b11, 0);
    send(3'd3, 0, 1, 2'b11, 0);
    send(3'd4, 1, 1, 2'b11, 1);
    wait_res(base + 3);
    check(nres == base + 3, "R7", "pipelined result count", nres, base + 3);
    check(res_log[base] == code(ca) && chan_log[base] == 1, "R7", "first pipelined result",
          res_log[base], code(ca));
    check(nwr_at[base] == 4, "R7", "next byte written before read", nwr_at[base], 4);
    check(res_log[base+1] == code(cb) && chan_log[base+1] == 3, "R7", "second pipelined result",
          res_log[base+1], code(cb));
    check(res_log[base+2] == code(cc) && chan_log[base+2] == 4, "R8", "drained result",
          res_log[base+2], code(cc));
    check(nwr_at[base+2] == 5, "R8", "drain without write", nwr_at[base+2], 5);
    pipe_mode = 0;
  endtask

  task automatic t_timeout;
    int base, k = 0;
    base = nres;
    mute = 1;
    send(3'd0, 1, 1, 2'b11, 1);
    while (nerr == 0 && k < 5000) begin @(negedge clk); k++; end
    check(nerr == 1, "R9", "timeout pulse", nerr, 1);
    check(err_falls >= TMO_CLKS && err_falls <= TMO_CLKS + 2, "R9", "timeout window",
          err_falls, TMO_CLKS);
    check(nres == base, "R9", "no result on timeout", nres, base);
    check(req_ready, "R9", "idle after timeout", req_ready, 1);
    mute = 0;
    send(3'd6, 1, 1, 2'b11, 1);
    wait_res(base + 1);
    check(chan_log[base] == 6 && res_log[base] == code(ctl(3'd6, 1, 1, 2'b11)), "R9",
          "recovery after timeout", res_log[base], code(ctl(3'd6, 1, 1, 2'b11)));
  endtask

  task automatic t_bus_rules;
    check(v_cs == 0, "R11", "strobe without select", v_cs, 0);
    check(v_setup == 0 && v_wrlen == 0 && v_wroe == 0, "R3", "write timing",
          v_setup + v_wrlen + v_wroe, 0);
    check(v_oe == 0 && v_turn == 0, "R4", "turnaround", v_oe + v_turn, 0);
    check(v_rdlen == 0 && v_valid == 0, "R5", "read length and strobe slot",
          v_rdlen + v_valid, 0);
    check(v_clk == 0 && clk_edges > 100, "R10", "converter clock phases", v_clk, 0);
  endtask

  initial begin
    t_reset;
    t_normal;
    t_pipe;
    t_timeout;
    t_bus_rules;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule